// File: doc/BRIEF.md
# Leading-Element Predicate Mask Generator

This block turns a small request into a per-element predicate mask for a vector unit whose length is set at run time. Each request carries an element-size code, a 5-bit pattern code, the current vector length in bits and a 4-bit destination register index. The pattern code selects how many leading elements become active. Some codes give fixed counts. Others derive the count from the number of elements that fit in the current vector length. A fixed count that is larger than the number of elements gives an empty mask.

The mask carries one bit for every byte of vector length. Each element owns a group of bits whose size matches the element width, and only the lowest bit of each group can be set. Four condition flags are computed from the finished mask: first element active, no element active, last element inactive, and an overflow flag that is always clear. The mask, the flags and the destination index come out one clock after the request, with their own valid pulse. They are then held until the next request. The register file that receives the mask is outside this block.

Top module: `pred_mask_gen`

## Requirements
- R1: Element width is 8 << sizeCode bits. Element e owns mask bits e·2^sizeCode up to e·2^sizeCode + 2^sizeCode − 1, and only the lowest bit of that group may be 1.
- R2: The active elements form a prefix: element e is active exactly when e is below the decoded count. The first-element flag therefore never equals the empty flag in a response.
- R3: Pattern codes 1 to 8 request that many elements. Codes 9 to 13 request 16, 32, 64, 128 and 256 elements.
- R4: Pattern code 0 gives the largest power of two that does not exceed the element count (vecLen / element width).
- R5: Pattern code 29 gives the element count rounded down to a multiple of 4. Code 30 rounds it down to a multiple of 3. Code 31 gives every element.
- R6: When a fixed request (codes 1 to 13) exceeds the element count, the whole mask is 0.
- R7: Codes 14 to 28 give a count of zero and an all-zero mask, and the block otherwise responds normally.
- R8: Mask bits at positions vecLen/8 and above are 0. vecLen is a multiple of 128 from 128 up to MAX_VL.
- R9: flagN is 1 when element 0 is active. flagZ is 1 when no element is active. flagC is 1 when element (element count − 1) is inactive. flagV is always 0.
- R10: A request with reqValid high at one rising edge gives rspValid high after that edge for exactly one cycle. It also gives the mask, the flags and rspDst equal to the request's dstIdx. rspValid is never high without a request on the previous edge.
- R11: Reset clears rspValid, the mask, the flags and rspDst to 0. Without reqValid, changes on the request inputs leave every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request strobe |
| sizeCode | input | 2 | Element size code (8 << code bits) |
| patCode | input | 5 | Pattern code selecting the active count |
| vecLen | input | $clog2(MAX_VL+1) | Current vector length in bits |
| dstIdx | input | 4 | Destination register index |
| rspValid | output | 1 | One-cycle response strobe |
| predMask | output | MAX_VL/8 | Predicate mask, one bit per byte |
| flagN | output | 1 | First element active |
| flagZ | output | 1 | No element active |
| flagC | output | 1 | Last element inactive |
| flagV | output | 1 | Always 0 |
| rspDst | output | 4 | Destination index of the response |

## Verification
Every output register loads on the same edge, so a wrong count or a wrong group decode shows in predMask in the very next response. It appears as a prefix of the wrong length, as a bit set inside a group, or as a bit set past the vector length. The flags come from the registered mask's first and last element positions. An error in the last-element index therefore shows first as a wrong flagC on responses where the count sits just below the element count, such as patterns 29 and 30. A capture strobe that stays active too long shows one cycle after a request, as outputs that follow input changes made without reqValid.

// File: rtl/pred_mask_pkg.sv
package pred_mask_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;
  } ctlStrobe_t;

  // Pattern codes with a special meaning
  localparam logic [4:0] PAT_POW2      = 5'd0;
  localparam logic [4:0] PAT_FIX_FIRST = 5'd1;
  localparam logic [4:0] PAT_FIX_SMALL = 5'd8;
  localparam logic [4:0] PAT_FIX_LAST  = 5'd13;
  localparam logic [4:0] PAT_MUL4      = 5'd29;
  localparam logic [4:0] PAT_MUL3      = 5'd30;
  localparam logic [4:0] PAT_ALL       = 5'd31;

endpackage

// File: rtl/pred_cnt_decode.sv
module pred_cnt_decode
  import pred_mask_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic [CNT_W-1:0] elemCount,
  input  logic [4:0]       patCode,
  output logic [CNT_W-1:0] activeCount
);

  // Fixed requests reach 256, so keep at least 9 bits for them
  localparam int FIX_W = (CNT_W > 9) ? CNT_W : 9;

  logic [CNT_W-1:0] pow2Floor;
  logic [FIX_W-1:0] fixedReq;
  logic [FIX_W-1:0] elemWide;
  logic             isFixed;

  always_comb begin
    pow2Floor = '0;
    for (int b = 0; b < CNT_W; b++) begin
      if (elemCount[b]) pow2Floor = CNT_W'(1) << b;
    end
  end

  always_comb begin
    isFixed  = (patCode >= PAT_FIX_FIRST) && (patCode <= PAT_FIX_LAST);
    elemWide = FIX_W'(elemCount);
    if (patCode <= PAT_FIX_SMALL) begin
      fixedReq = FIX_W'(patCode);
    end else begin
      fixedReq = FIX_W'(16) << (patCode - 5'd9);
    end
  end

  always_comb begin
    if (patCode == PAT_POW2) begin
      activeCount = pow2Floor;
    end else if (isFixed) begin
      activeCount = (fixedReq > elemWide) ? '0 : CNT_W'(fixedReq);
    end else if (patCode == PAT_MUL4) begin
      activeCount = elemCount & ~CNT_W'(3);
    end else if (patCode == PAT_MUL3) begin
      activeCount = (elemCount / CNT_W'(3)) * CNT_W'(3);
    end else if (patCode == PAT_ALL) begin
      activeCount = elemCount;
    end else begin
      activeCount = '0;
    end
  end

endmodule

// File: rtl/pred_mask_ctrl.sv
module pred_mask_ctrl
  import pred_mask_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output ctlStrobe_t ctl,
  output logic       rspValid
);

  always_comb begin
    ctl.capture = reqValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= reqValid;
  end

endmodule

// File: rtl/pred_mask_dp.sv
module pred_mask_dp
  import pred_mask_pkg::*;
#(
  parameter int MAX_VL = 2048
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctlStrobe_t                   ctl,
  input  logic [1:0]                   sizeCode,
  input  logic [4:0]                   patCode,
  input  logic [$clog2(MAX_VL+1)-1:0]  vecLen,
  input  logic [3:0]                   dstIdx,
  output logic [MAX_VL/8-1:0]          predMask,
  output logic                         flagN,
  output logic                         flagZ,
  output logic                         flagC,
  output logic                         flagV,
  output logic [3:0]                   rspDst
);

  localparam int PW    = MAX_VL / 8;
  localparam int CNT_W = $clog2(PW + 1);
  localparam int IDX_W = $clog2(PW);

  logic [CNT_W-1:0] elemCount;
  logic [CNT_W-1:0] vlBytes;
  logic [CNT_W-1:0] activeCount;
  logic [PW-1:0]    nextMask;
  logic [IDX_W-1:0] lastPos;
  logic             nextN, nextZ, nextC;

  assign elemCount = CNT_W'(vecLen >> (3 + sizeCode));
  assign vlBytes   = CNT_W'(vecLen >> 3);

  pred_cnt_decode #(.CNT_W(CNT_W)) i_decode (
    .elemCount  (elemCount),
    .patCode    (patCode),
    .activeCount(activeCount)
  );

  // One lane per predicate bit
  for (genvar gi = 0; gi < PW; gi++) begin : gBit
    localparam logic [IDX_W-1:0] BIT_POS = IDX_W'(gi);
    logic [IDX_W-1:0] elemIdx;
    logic             groupLead;
    assign elemIdx   = BIT_POS >> sizeCode;
    assign groupLead = (BIT_POS & ((IDX_W'(1) << sizeCode) - IDX_W'(1))) == '0;
    assign nextMask[gi] = groupLead
                        && (CNT_W'(elemIdx) < activeCount)
                        && (CNT_W'(BIT_POS) < vlBytes);
  end

  // Flags are read back from the mask at the first and last element
  assign lastPos = IDX_W'((elemCount - CNT_W'(1)) << sizeCode);
  assign nextN   = nextMask[0];
  assign nextZ   = ~|nextMask;
  assign nextC   = ~nextMask[lastPos];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      predMask <= '0;
      flagN    <= 1'b0;
      flagZ    <= 1'b0;
      flagC    <= 1'b0;
      rspDst   <= '0;
    end else if (ctl.capture) begin
      predMask <= nextMask;
      flagN    <= nextN;
      flagZ    <= nextZ;
      flagC    <= nextC;
      rspDst   <= dstIdx;
    end
  end

  assign flagV = 1'b0;

endmodule

// File: rtl/pred_mask_gen.sv
module pred_mask_gen
  import pred_mask_pkg::*;
#(
  parameter int MAX_VL = 2048
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         reqValid,
  input  logic [1:0]                   sizeCode,
  input  logic [4:0]                   patCode,
  input  logic [$clog2(MAX_VL+1)-1:0]  vecLen,
  input  logic [3:0]                   dstIdx,
  output logic                         rspValid,
  output logic [MAX_VL/8-1:0]          predMask,
  output logic                         flagN,
  output logic                         flagZ,
  output logic                         flagC,
  output logic                         flagV,
  output logic [3:0]                   rspDst
);

  ctlStrobe_t ctl;

  pred_mask_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .ctl     (ctl),
    .rspValid(rspValid)
  );

  pred_mask_dp #(.MAX_VL(MAX_VL)) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .sizeCode(sizeCode),
    .patCode (patCode),
    .vecLen  (vecLen),
    .dstIdx  (dstIdx),
    .predMask(predMask),
    .flagN   (flagN),
    .flagZ   (flagZ),
    .flagC   (flagC),
    .flagV   (flagV),
    .rspDst  (rspDst)
  );

endmodule

// File: rtl/pred_mask_checker.sv
module pred_mask_checker #(
  parameter int MAX_VL = 2048
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         reqValid,
  input logic [1:0]                   sizeCode,
  input logic [$clog2(MAX_VL+1)-1:0]  vecLen,
  input logic [3:0]                   dstIdx,
  input logic                         rspValid,
  input logic [MAX_VL/8-1:0]          predMask,
  input logic                         flagN,
  input logic                         flagZ,
  input logic                         flagC,
  input logic                         flagV,
  input logic [3:0]                   rspDst
);

  localparam int PW    = MAX_VL / 8;
  localparam int IDX_W = $clog2(PW);
  localparam int VB_W  = $clog2(PW + 1);

  logic [IDX_W-1:0] lastQ;
  logic [VB_W-1:0]  vlBytesQ;
  logic [PW-1:0]    nonLeadQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastQ    <= '0;
      vlBytesQ <= '0;
      nonLeadQ <= '0;
    end else if (reqValid) begin
      lastQ    <= IDX_W'(((vecLen >> (3 + sizeCode)) - 1'b1) << sizeCode);
      vlBytesQ <= VB_W'(vecLen >> 3);
      for (int i = 0; i < PW; i++) begin
        nonLeadQ[i] <= (IDX_W'(i) & ((IDX_W'(1) << sizeCode) - IDX_W'(1))) != '0;
      end
    end
  end

  AST_GROUP_LEAD_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> ((predMask & nonLeadQ) == '0)); // R1
  AST_PREFIX_N_NOT_Z: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (flagN != flagZ)); // R2
  AST_BEYOND_VL_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> ((predMask >> vlBytesQ) == '0)); // R8
  AST_Z_FLAG_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (flagZ == (predMask == '0))); // R9
  AST_C_FLAG_LAST: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (flagC == !predMask[lastQ])); // R9
  AST_V_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !flagV); // R9
  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (rspValid && rspDst == $past(dstIdx))); // R10
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid); // R10
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> ($stable(predMask) && $stable(flagN) && $stable(flagZ)
                   && $stable(flagC) && $stable(rspDst))); // R11

endmodule

bind pred_mask_gen pred_mask_checker #(.MAX_VL(MAX_VL)) i_checker (
  .clk     (clk),
  .rstN    (rstN),
  .reqValid(reqValid),
  .sizeCode(sizeCode),
  .vecLen  (vecLen),
  .dstIdx  (dstIdx),
  .rspValid(rspValid),
  .predMask(predMask),
  .flagN   (flagN),
  .flagZ   (flagZ),
  .flagC   (flagC),
  .flagV   (flagV),
  .rspDst  (rspDst)
);

// File: tb/test_pred_mask_gen.sv
module test_pred_mask_gen;

  localparam int MAX_VL = 2048;
  localparam int PW     = MAX_VL / 8;
  localparam int VL_W   = $clog2(MAX_VL + 1);

  logic            clk = 1'b0;
  logic            rstN;
  logic            reqValid;
  logic [1:0]      sizeCode;
  logic [4:0]      patCode;
  logic [VL_W-1:0] vecLen;
  logic [3:0]      dstIdx;
  logic            rspValid;
  logic [PW-1:0]   predMask;
  logic            flagN, flagZ, flagC, flagV;
  logic [3:0]      rspDst;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pred_mask_gen #(.MAX_VL(MAX_VL)) i_pred_mask_gen (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .sizeCode(sizeCode),
    .patCode(patCode), .vecLen(vecLen), .dstIdx(dstIdx), .rspValid(rspValid),
    .predMask(predMask), .flagN(flagN), .flagZ(flagZ), .flagC(flagC),
    .flagV(flagV), .rspDst(rspDst)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [PW-1:0] act, input logic [PW-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int expCount(int p, int el);
    int f;
    if (p == 0) begin
      f = 1;
      while (f * 2 <= el) f = f * 2;
      return f;
    end
    if (p >= 1 && p <= 13) begin
      f = (p <= 8) ? p : (16 << (p - 9));
      return (f > el) ? 0 : f;
    end
    if (p == 29) return el - (el % 4);
    if (p == 30) return el - (el % 3);
    if (p == 31) return el;
    return 0;
  endfunction

  function automatic logic [PW-1:0] expMask(int s, int vl, int cnt);
    logic [PW-1:0] m;
    int psz;
    m = '0;
    psz = 1 << s;
    for (int i = 0; i < PW; i++) begin
      if (i < vl / 8 && i % psz == 0 && i / psz < cnt) m[i] = 1'b1;
    end
    return m;
  endfunction

  function automatic string patTag(int p, int el);
    int f;
    if (p == 0) return "R2 R4";
    if (p >= 1 && p <= 13) begin
      f = (p <= 8) ? p : (16 << (p - 9));
      return (f > el) ? "R6" : "R2 R3";
    end
    if (p >= 29) return "R2 R5";
    return "R7";
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL R10 watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin : stimulus
    logic [PW-1:0] em, nonLead, hMask;
    logic [3:0]    hFlags, hDst;
    int            el, cnt, n;
    rstN     = 1'b0;
    reqValid = 1'b0;
    sizeCode = '0;
    patCode  = '0;
    vecLen   = VL_W'(128);
    dstIdx   = '0;
    repeat (2) @(negedge clk);
    // R11 reset state
    check(rspValid == 1'b0, "R11", "reset rspValid", PW'(rspValid), '0);
    check(predMask == '0, "R11", "reset predMask", predMask, '0);
    check({flagN, flagZ, flagC, flagV, rspDst} == '0, "R11", "reset flags/dst",
          PW'({flagN, flagZ, flagC, flagV, rspDst}), '0);
    rstN = 1'b1;
    @(negedge clk);
    n = 0;
    for (int s = 0; s < 4; s++) begin
      for (int k = 1; k <= MAX_VL / 128; k++) begin
        for (int p = 0; p < 32; p++) begin
          sizeCode = 2'(s);
          patCode  = 5'(p);
          vecLen   = VL_W'(128 * k);
          dstIdx   = 4'(n);
          reqValid = 1'b1;
          @(negedge clk);
          reqValid = 1'b0;
          el  = (128 * k) / (8 << s);
          cnt = expCount(p, el);
          em  = expMask(s, 128 * k, cnt);
          nonLead = '0;
          for (int i = 0; i < PW; i++) if (i % (1 << s) != 0) nonLead[i] = 1'b1;
          check(predMask == em, patTag(p, el), "mask", predMask, em);
          check((predMask & nonLead) == '0, "R1", "non-lead bits", predMask & nonLead, '0);
          check((predMask >> ((128 * k) / 8)) == '0, "R8", "bits beyond VL",
                predMask >> ((128 * k) / 8), '0);
          check({flagN, flagZ, flagC, flagV} == {cnt > 0, cnt == 0, cnt < el, 1'b0},
                "R9", "flags NZCV", PW'({flagN, flagZ, flagC, flagV}),
                PW'({cnt > 0, cnt == 0, cnt < el, 1'b0}));
          check(rspValid == 1'b1 && rspDst == 4'(n), "R10", "valid+dst",
                PW'({rspValid, rspDst}), PW'({1'b1, 4'(n)}));
          // Idle inputs change; nothing may move (R11)
          hMask = predMask; hFlags = {flagN, flagZ, flagC, flagV}; hDst = rspDst;
          sizeCode = 2'(s + 1);
          patCode  = 5'(p + 7);
          vecLen   = VL_W'(MAX_VL);
          dstIdx   = 4'(n + 5);
          @(negedge clk);
          check(rspValid == 1'b0, "R10", "single-cycle valid", PW'(rspValid), '0);
          check(predMask == hMask && {flagN, flagZ, flagC, flagV} == hFlags && rspDst == hDst,
                "R11", "hold without request", predMask, hMask);
          n++;
        end
      end
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule